// File: doc/BRIEF.md
# Multi-Channel Single-Edge PWM Timer

This block is a 32-bit up-counter with four compare channels. Each channel drives one output pin. The pin is either a single-edge PWM waveform or a plain bit that software sets directly. One compare channel, selected by a parameter and channel 3 by default, sets the length of the PWM cycle. When the counter reaches that channel's compare value, it returns to zero on the next count tick.

The counter advances only when the count tick input is high. The tick normally comes from a prescaler outside this block. Every PWM pin update also happens on a tick. A PWM pin rises when the counter reaches its channel's compare value. It falls when the counter returns to zero. Zero, equal-to-period and beyond-period compare values give defined constant or pulse waveforms.

Configuration uses a small register port. Writes take effect at the clock edge. Reads are combinational. The port has no handshake: a write is accepted in the cycle where the write strobe is high, and the port never applies back-pressure. The block has no streaming data path, so no valid/ready interface is needed.

Register map:

| Address | Contents |
|---|---|
| 0 to 3 | Compare value of channels 0 to 3 |
| 4 | PWM mode enable, one bit per channel in bits 3:0 |
| 5 | Direct output bit, one bit per channel in bits 3:0 |

Top module: `pwm_match_timer`

## Requirements
- R1: After reset, the counter, all four compare values, the PWM enable bits, the direct output bits and all four output pins are zero.
- R2: The counter holds its value in any cycle where `tick_en` is low. No PWM pin changes in such a cycle.
- R3: On a tick where the counter equals the compare value at address 3, the counter goes to zero. On any other tick it increments by one.
- R4: On a tick where the counter's next value equals a channel's compare value, and that value is nonzero, the channel's PWM waveform goes high.
- R5: On every tick where the counter's next value is zero (the cycle start), a channel whose compare value is nonzero goes low.
- R6: A channel whose compare value is above the period value never goes high in PWM mode; it stays low.
- R7: If a channel's compare value is raised above the period while its PWM waveform is high, the waveform stays high until the next cycle start and is low from then on.
- R8: A channel whose compare value equals the period value produces a high pulse of exactly one tick at the end of each cycle.
- R9: A channel whose compare value is zero goes high at the first cycle start and then stays high.
- R10: When a channel's enable bit is 0, its output pin equals its direct output bit. When the bit is 1, the pin shows the PWM waveform.
- R11: Bits 31:4 of the enable register (address 4) and of the direct output register (address 5) read as zero, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| match_out | output | 4 | Channel output pins |

## Verification
The bench targets the compare values that sit at the edges of the cycle.

- A compare value equal to the period must give a single-tick pulse. A design that compared the current count instead of the next count would move or stretch that pulse.
- A zero compare value must give constant high. A design that did not special-case zero would pulse low once per cycle or never rise.
- A compare value raised above the period in mid-cycle must keep the pin high until the cycle start. A design that re-evaluated the comparison every tick would drop the pin early.
- Ticks are withheld in some stretches. A design that counted or updated pins on every clock would drift against the reference.

Writes carrying ones in the reserved bits must read back with those bits clear.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned NCH    = 4;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned A_EN   = NCH;
  localparam int unsigned A_EXT  = NCH + 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int unsigned W      = 32,
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      cmp_q [NCH],
  output logic [NCH-1:0]    pwm_mode_q,
  output logic [NCH-1:0]    direct_q
);
  localparam int unsigned A_EN  = NCH;
  localparam int unsigned A_EXT = NCH + 1;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        cmp_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_mode_q <= '0;
      direct_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_EN))  pwm_mode_q <= wr_data[NCH-1:0];
      if (wr_addr == ADDR_W'(A_EXT)) direct_q   <= wr_data[NCH-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = cmp_q[i];
    if (rd_addr == ADDR_W'(A_EN))  rd_data[NCH-1:0] = pwm_mode_q;
    if (rd_addr == ADDR_W'(A_EXT)) rd_data[NCH-1:0] = direct_q;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_next,
  output logic         cyc_start
);
  logic at_period;

  always_comb begin
    at_period = (cnt_q == period);
    cnt_next  = at_period ? '0 : cnt_q + W'(1);
    cyc_start = tick_en && (cnt_next == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (tick_en)
      cnt_q <= cnt_next;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         cyc_start,
  input  logic [W-1:0] cnt_next,
  input  logic [W-1:0] cmp,
  input  logic         pwm_mode,
  input  logic         direct,
  output logic         pin
);
  logic wave_q;
  logic cmp_zero;

  assign cmp_zero = (cmp == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      wave_q <= 1'b0;
    else if (cyc_start)
      wave_q <= cmp_zero;
    else if (tick_en && cnt_next == cmp)
      wave_q <= 1'b1;
  end

  assign pin = pwm_mode ? wave_q : direct;
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int unsigned PERIOD_CH = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic                        wr_en,
  input  logic [pwm_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [pwm_pkg::CNT_W-1:0]   wr_data,
  input  logic [pwm_pkg::ADDR_W-1:0]  rd_addr,
  output logic [pwm_pkg::CNT_W-1:0]   rd_data,
  output logic [pwm_pkg::NCH-1:0]     match_out
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] cmp_q [NCH];
  logic [NCH-1:0]   pwm_mode_q;
  logic [NCH-1:0]   direct_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             cyc_start;

  pwm_regs #(.W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_q(cmp_q), .pwm_mode_q(pwm_mode_q), .direct_q(direct_q)
  );

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period(cmp_q[PERIOD_CH]),
    .cnt_q(cnt_q), .cnt_next(cnt_next), .cyc_start(cyc_start)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cyc_start(cyc_start),
      .cnt_next(cnt_next), .cmp(cmp_q[i]), .pwm_mode(pwm_mode_q[i]),
      .direct(direct_q[i]), .pin(match_out[i])
    );
  end
endmodule

module pwm_match_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wr_en,
  input logic [2:0]  rd_addr,
  input logic [31:0] rd_data,
  input logic [31:0] cnt_q,
  input logic [31:0] period,
  input logic [31:0] cmp0,
  input logic        mode0,
  input logic [3:0]  match_out
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_q == period) |=> cnt_q == 32'd0);
  // R5
  cyc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && cnt_q == period && cmp0 != 32'd0 && mode0) |=> !match_out[0]);
  // R2
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(match_out));
  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd4 || rd_addr == 3'd5) |-> rd_data[31:4] == 28'd0);
endmodule

bind pwm_match_timer pwm_match_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .cnt_q(cnt_q),
  .period(cmp_q[PERIOD_CH]), .cmp0(cmp_q[0]), .mode0(pwm_mode_q[0]),
  .match_out(match_out)
);

// File: tb/pwm_match_timer_tb.sv
module pwm_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  match_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [3:0] pins; string tag; } exp_t;
  exp_t sbq[$];

  // reference state
  logic [31:0] mc;
  logic [31:0] mm [4];
  logic [3:0]  mwave, men, mext;

  always #2 clk = ~clk;

  pwm_match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .match_out(match_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare pins shortly after every edge that has an expectation
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(e.tag, {28'd0, match_out}, {28'd0, e.pins});
    end
  end

  // driver: one cycle of stimulus plus the expected pins after the edge
  task automatic step(input bit tk, input bit we, input logic [2:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] nxt;
    exp_t e;
    @(negedge clk);
    tick_en = tk; wr_en = we; wr_addr = a; wr_data = d;
    if (tk) begin
      nxt = (mc == mm[3]) ? 32'd0 : mc + 32'd1;
      for (int i = 0; i < 4; i++) begin
        if (nxt == 32'd0)      mwave[i] = (mm[i] == 32'd0);
        else if (nxt == mm[i]) mwave[i] = 1'b1;
      end
      mc = nxt;
    end
    if (we) begin
      if (a < 3'd4) mm[a[1:0]] = d;
      else if (a == 3'd4) men = d[3:0];
      else if (a == 3'd5) mext = d[3:0];
    end
    e.pins = (men & mwave) | (~men & mext);
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mc = '0; mwave = '0; men = '0; mext = '0;
    for (int i = 0; i < 4; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values through the read port and pins
    for (int a = 0; a < 6; a++) begin
      rd_addr = 3'(a); #0.1;
      check("R1 reg reset", rd_data, 32'd0);
    end
    check("R1 pins reset", {28'd0, match_out}, 32'd0);

    // period 9, ch0 mid, ch1 equal to period, ch2 zero
    step(0, 1, 3'd3, 32'd9, "R2 config");
    step(0, 1, 3'd0, 32'd3, "R2 config");
    step(0, 1, 3'd1, 32'd9, "R2 config");
    step(0, 1, 3'd2, 32'd0, "R2 config");
    step(0, 1, 3'd4, 32'hFFFF_FFF7, "R11 enable write");
    @(negedge clk); rd_addr = 3'd4; #0.1;
    check("R11 enable readback", rd_data, 32'h7);
    run(25, "R4 R5 R8 R9 waveform");
    // R2: no ticks, pins frozen
    for (int k = 0; k < 6; k++) step(0, 0, 3'd0, 32'd0, "R2 hold");
    run(7, "R3 R4 resume");
    // R7: ch0 high now (count between 3 and 9); move compare beyond period
    run(4, "R4 rise");
    step(1, 1, 3'd0, 32'd20, "R7 raise while high");
    run(22, "R6 R7 above period");
    // R10: direct output mode
    step(0, 1, 3'd5, 32'hFFFF_FFF5, "R10 direct bits");
    @(negedge clk); rd_addr = 3'd5; #0.1;
    check("R11 direct readback", rd_data, 32'h5);
    step(0, 1, 3'd4, 32'd0, "R10 all direct");
    run(12, "R10 direct follows");
    step(0, 1, 3'd5, 32'hA, "R10 direct change");
    step(0, 1, 3'd4, 32'h2, "R10 mixed");
    run(15, "R8 R10 mixed");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule